// File: doc/BRIEF.md
# Pipelined Composite-Field Byte Substitution Unit

This block performs the AES byte substitution, in either direction, without a 256-entry table. Each incoming byte is moved by a linear change of basis into a tower field built from 4-bit elements. The multiplicative inverse is formed there from nibble squaring, nibble products and a scaling constant. The result is then mapped back to the standard byte representation. In the forward direction the affine step follows the inversion. In the inverse direction the inverse affine step comes before the inversion.

The datapath is divided into three register stages, so a new byte can be accepted on every clock whatever the direction. A mode bit travels with each byte. Outputs return in the same order as the inputs, with a matching valid strobe. A cipher round would place sixteen of these units side by side. That wrapper is not part of this block.

Top module: `gf_sbox_pipe`

## Requirements
- R1: With `in_inv` = 0, the byte on `out_byte` is the forward substitution of the input. It is the affine map applied to the inverse of the input in GF(2^8), reduced modulo x^8+x^4+x^3+x+1. In the affine map, result bit i = b[i]^b[(i+4)%8]^b[(i+5)%8]^b[(i+6)%8]^b[(i+7)%8]^c[i], with c = 8'h63.
- R2: With `in_inv` = 1, the byte on `out_byte` is the inverse substitution of the input. The inverse affine map is applied first, with bit i = a[(i+2)%8]^a[(i+5)%8]^a[(i+7)%8]^d[i] and d = 8'h05. The field inverse is then taken.
- R3: The inverse of zero is taken as zero. Forward mode maps 8'h00 to 8'h63, and inverse mode maps 8'h63 to 8'h00.
- R4: Forward mode maps 8'h04 to 8'hF2, since the inverse of 8'h04 is 8'hCB. Inverse mode maps 8'hF2 back to 8'h04.
- R5: A byte sampled with `in_valid` high on a rising edge appears on `out_byte`, with `out_valid` high, after the third rising edge, counting the sampling edge as the first.
- R6: Bytes presented on consecutive clocks come out on consecutive clocks, in order. The direction may change on every byte.
- R7: A synchronous active-high `rst` drops every byte in flight. `out_valid` is low in the cycle after any reset edge, and it stays low until a byte accepted after reset reaches the output.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low three edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present this cycle |
| in_inv | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Output byte is present this cycle |
| out_byte | output | 8 | Substituted byte |

## Verification
A wrong coefficient in either basis map, in a nibble product or in the scaling constant does not cause a small error. It corrupts the substitution of most byte values in both directions. Each such error shows as a mismatched `out_byte` exactly three cycles after the affected byte is accepted. An error in the staged valid or mode flags shows in the same cycle as a missing or extra `out_valid`, or as a byte substituted in the wrong direction. Sweeping all 256 values in each direction, back-to-back and interleaved with bubbles and direction changes, exposes each of these faults within a few cycles of the first byte it touches.

// File: rtl/sbox_gf_pkg.sv
package sbox_gf_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = BYTE_W / 2;
    localparam int PAIR_W   = NIB_W / 2;
    localparam int LATENCY  = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [PAIR_W-1:0] pair_t;

    localparam nib_t  LAMBDA    = 4'b1100;
    localparam byte_t FWD_CONST = 8'h63;
    localparam byte_t INV_CONST = 8'h05;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } sub_dir_e;

    // Register contents after the basis-change stage
    typedef struct packed {
        logic     vld;
        sub_dir_e dir;
        nib_t     hi;
        nib_t     sum;
        nib_t     lo;
        nib_t     hi_sq;
    } map_reg_t;

    // Register contents after the norm-computation stage
    typedef struct packed {
        logic     vld;
        sub_dir_e dir;
        nib_t     hi;
        nib_t     sum;
        nib_t     norm;
    } norm_reg_t;

    // Register contents after the final stage
    typedef struct packed {
        logic  vld;
        byte_t data;
    } out_reg_t;

    // Product in GF(2^2), polynomial x^2+x+1
    function automatic pair_t gf2_mul(input pair_t a, input pair_t b);
        pair_t r;
        r[1] = (a[1] & b[1]) ^ (a[0] & b[1]) ^ (a[1] & b[0]);
        r[0] = (a[1] & b[1]) ^ (a[0] & b[0]);
        return r;
    endfunction

    // Scaling by the element 2'b10 in GF(2^2)
    function automatic pair_t gf2_phi(input pair_t a);
        return {a[1] ^ a[0], a[1]};
    endfunction

    // Product in GF((2^2)^2), polynomial y^2+y+phi
    function automatic nib_t gf4_mul(input nib_t a, input nib_t b);
        pair_t hh, hl, lh, ll;
        hh = gf2_mul(a[3:2], b[3:2]);
        hl = gf2_mul(a[3:2], b[1:0]);
        lh = gf2_mul(a[1:0], b[3:2]);
        ll = gf2_mul(a[1:0], b[1:0]);
        return {hh ^ hl ^ lh, gf2_phi(hh) ^ ll};
    endfunction

    function automatic nib_t gf4_sq(input nib_t a);
        return gf4_mul(a, a);
    endfunction

    // Inverse as a^14 = a^2 * a^4 * a^8; zero maps to zero
    function automatic nib_t gf4_inv(input nib_t a);
        nib_t p2, p4, p8;
        p2 = gf4_sq(a);
        p4 = gf4_sq(p2);
        p8 = gf4_sq(p4);
        return gf4_mul(gf4_mul(p2, p4), p8);
    endfunction

    // Standard byte basis into the tower basis
    function automatic byte_t iso_map(input byte_t j);
        byte_t r;
        r[7] = j[7] ^ j[5];
        r[6] = j[7] ^ j[6] ^ j[4] ^ j[3] ^ j[2] ^ j[1];
        r[5] = j[7] ^ j[5] ^ j[3] ^ j[2];
        r[4] = j[7] ^ j[5] ^ j[3] ^ j[2] ^ j[1];
        r[3] = j[7] ^ j[6] ^ j[2] ^ j[1];
        r[2] = j[7] ^ j[4] ^ j[3] ^ j[2] ^ j[1];
        r[1] = j[6] ^ j[4] ^ j[1];
        r[0] = j[6] ^ j[1] ^ j[0];
        return r;
    endfunction

    // Tower basis back into the standard byte basis
    function automatic byte_t iso_unmap(input byte_t j);
        byte_t r;
        r[7] = j[7] ^ j[6] ^ j[5] ^ j[1];
        r[6] = j[6] ^ j[2];
        r[5] = j[6] ^ j[5] ^ j[1];
        r[4] = j[6] ^ j[5] ^ j[4] ^ j[2] ^ j[1];
        r[3] = j[5] ^ j[4] ^ j[3] ^ j[2] ^ j[1];
        r[2] = j[7] ^ j[4] ^ j[3] ^ j[2] ^ j[1];
        r[1] = j[5] ^ j[4];
        r[0] = j[6] ^ j[5] ^ j[4] ^ j[2] ^ j[0];
        return r;
    endfunction

    function automatic byte_t affine_fwd(input byte_t b);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[i] ^ b[(i + 4) % BYTE_W] ^ b[(i + 5) % BYTE_W]
                 ^ b[(i + 6) % BYTE_W] ^ b[(i + 7) % BYTE_W] ^ FWD_CONST[i];
        end
        return r;
    endfunction

    function automatic byte_t affine_inv(input byte_t a);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = a[(i + 2) % BYTE_W] ^ a[(i + 5) % BYTE_W]
                 ^ a[(i + 7) % BYTE_W] ^ INV_CONST[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/sbox_map_stage.sv
module sbox_map_stage
    import sbox_gf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  sub_dir_e in_dir,
    input  byte_t    in_byte,
    output map_reg_t stage_q
);

    byte_t    pre_byte;
    byte_t    tower;
    map_reg_t stage_d;

    always_comb begin
        pre_byte       = (in_dir == DIR_INV) ? affine_inv(in_byte) : in_byte;
        tower          = iso_map(pre_byte);
        stage_d.vld    = in_valid;
        stage_d.dir    = in_dir;
        stage_d.hi     = tower[BYTE_W-1:NIB_W];
        stage_d.lo     = tower[NIB_W-1:0];
        stage_d.sum    = tower[BYTE_W-1:NIB_W] ^ tower[NIB_W-1:0];
        stage_d.hi_sq  = gf4_sq(tower[BYTE_W-1:NIB_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

endmodule

// File: rtl/sbox_norm_stage.sv
module sbox_norm_stage
    import sbox_gf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  map_reg_t  stage_in,
    output norm_reg_t stage_q
);

    norm_reg_t stage_d;

    always_comb begin
        stage_d.vld  = stage_in.vld;
        stage_d.dir  = stage_in.dir;
        stage_d.hi   = stage_in.hi;
        stage_d.sum  = stage_in.sum;
        stage_d.norm = gf4_mul(stage_in.hi_sq, LAMBDA)
                     ^ gf4_mul(stage_in.sum, stage_in.lo);
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

endmodule

// File: rtl/sbox_inv_stage.sv
module sbox_inv_stage
    import sbox_gf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  norm_reg_t stage_in,
    output out_reg_t  stage_q
);

    nib_t     norm_inv;
    byte_t    tower_inv;
    byte_t    plain_inv;
    out_reg_t stage_d;

    always_comb begin
        norm_inv     = gf4_inv(stage_in.norm);
        tower_inv    = {gf4_mul(stage_in.hi, norm_inv),
                        gf4_mul(stage_in.sum, norm_inv)};
        plain_inv    = iso_unmap(tower_inv);
        stage_d.vld  = stage_in.vld;
        stage_d.data = (stage_in.dir == DIR_FWD) ? affine_fwd(plain_inv) : plain_inv;
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

endmodule

// File: rtl/gf_sbox_pipe.sv
module gf_sbox_pipe
    import sbox_gf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_inv,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);

    sub_dir_e  dir_in;
    map_reg_t  map_q;
    norm_reg_t norm_q;
    out_reg_t  fin_q;

    assign dir_in = in_inv ? DIR_INV : DIR_FWD;

    sbox_map_stage u_map (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_dir   (dir_in),
        .in_byte  (in_byte),
        .stage_q  (map_q)
    );

    sbox_norm_stage u_norm (
        .clk      (clk),
        .rst      (rst),
        .stage_in (map_q),
        .stage_q  (norm_q)
    );

    sbox_inv_stage u_inv (
        .clk      (clk),
        .rst      (rst),
        .stage_in (norm_q),
        .stage_q  (fin_q)
    );

    assign out_valid = fin_q.vld;
    assign out_byte  = fin_q.data;

endmodule

// File: rtl/gf_sbox_pipe_checker.sv
module gf_sbox_pipe_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_inv,
    input logic [7:0] in_byte,
    input logic       out_valid,
    input logic [7:0] out_byte
);

    // Counts edges since reset so that no check looks back past it
    logic [1:0] since_rst;
    logic       hist_ok;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign hist_ok = (since_rst == 2'd3);

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        hist_ok |-> (out_valid == $past(in_valid, 3)));

    assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && !$past(in_valid, 3)) |-> !out_valid);

    assert_reset_flush_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    assert_zero_fwd_R3: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(in_valid, 3) && !$past(in_inv, 3) && $past(in_byte, 3) == 8'h00)
        |-> (out_byte == 8'h63));

    assert_zero_inv_R3: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(in_valid, 3) && $past(in_inv, 3) && $past(in_byte, 3) == 8'h63)
        |-> (out_byte == 8'h00));

    assert_known_fwd_R4: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(in_valid, 3) && !$past(in_inv, 3) && $past(in_byte, 3) == 8'h04)
        |-> (out_byte == 8'hF2));

    assert_known_inv_R4: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(in_valid, 3) && $past(in_inv, 3) && $past(in_byte, 3) == 8'hF2)
        |-> (out_byte == 8'h04));

endmodule

bind gf_sbox_pipe gf_sbox_pipe_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_inv    (in_inv),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_byte  (out_byte)
);

// File: tb/gf_sbox_pipe_bench.sv
module gf_sbox_pipe_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_inv = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;

    int checks = 0;
    int fails  = 0;
    int after_rst = 0;

    logic [7:0] fwd_tab [256];
    logic [7:0] inv_tab [256];

    // Expected pipeline contents, oldest first
    int qv[$];
    int qm[$];
    int qd[$];

    always #10 clk = ~clk;

    gf_sbox_pipe u_gf_sbox_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_inv    (in_inv),
        .in_byte   (in_byte),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );

    function automatic int fmul(int a, int b);
        int p = 0;
        for (int k = 0; k < 8; k++) begin
            if (b & 1) p ^= a;
            a = a << 1;
            if (a & 256) a ^= 'h11B;
            b = b >> 1;
        end
        return p & 255;
    endfunction

    function automatic int finv(int a);
        if (a == 0) return 0;
        for (int b = 1; b < 256; b++) if (fmul(a, b) == 1) return b;
        return 0;
    endfunction

    function automatic int bit_of(int v, int i);
        return (v >> (i % 8)) & 1;
    endfunction

    function automatic int aff(int b);
        int r = 0;
        for (int i = 0; i < 8; i++)
            r |= (bit_of(b, i) ^ bit_of(b, i + 4) ^ bit_of(b, i + 5) ^ bit_of(b, i + 6)
                  ^ bit_of(b, i + 7) ^ bit_of('h63, i)) << i;
        return r;
    endfunction

    function automatic int inv_aff(int a);
        int r = 0;
        for (int i = 0; i < 8; i++)
            r |= (bit_of(a, i + 2) ^ bit_of(a, i + 5) ^ bit_of(a, i + 7) ^ bit_of('h05, i)) << i;
        return r;
    endfunction

    function automatic string data_tag(int m, int d);
        if ((m == 0 && d == 0) || (m == 1 && d == 'h63)) return "R3";
        if ((m == 0 && d == 4) || (m == 1 && d == 'hF2)) return "R4";
        return (m == 1) ? "R2" : "R1";
    endfunction

    task automatic compare(input string phase);
        int ev, em, ed, exp_b;
        string vtag;
        ev = qv.pop_front();
        em = qm.pop_front();
        ed = qd.pop_front();
        vtag = (after_rst > 0) ? "R7" : (ev != 0 ? "R5" : "R8");
        if (after_rst > 0) after_rst--;
        checks++;
        if (int'(out_valid) != ev) begin
            fails++;
            $display("FAIL %s (%s) out_valid actual %0d expected %0d", vtag, phase, out_valid, ev);
        end
        if (ev != 0) begin
            exp_b = (em != 0) ? int'(inv_tab[ed]) : int'(fwd_tab[ed]);
            checks++;
            if (int'(out_byte) != exp_b) begin
                fails++;
                $display("FAIL %s (%s) in %02h dir %0d out_byte actual %02h expected %02h",
                         data_tag(em, ed), phase, ed, em, out_byte, exp_b);
            end
        end
    endtask

    // Called at a falling edge: check, drive the next input, wait one cycle
    task automatic step(input int v, input int m, input int d, input string phase);
        compare(phase);
        in_valid = v[0];
        in_inv   = m[0];
        in_byte  = d[7:0];
        qv.push_back(v);
        qm.push_back(m);
        qd.push_back(d & 255);
        @(negedge clk);
    endtask

    task automatic reset_step();
        compare("before reset");
        rst      = 1'b1;
        in_valid = 1'b1;
        in_byte  = 8'h04;
        qv.delete(); qm.delete(); qd.delete();
        for (int k = 0; k < 3; k++) begin
            qv.push_back(0); qm.push_back(0); qd.push_back(0);
        end
        @(negedge clk);
        rst = 1'b0;
        after_rst = 3;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int x = 0; x < 256; x++) begin
            fwd_tab[x] = 8'(aff(finv(x)));
            inv_tab[x] = 8'(finv(inv_aff(x)));
        end

        // Reset state (R7)
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL R7 reset state out_valid actual %0d expected 0", out_valid);
            end
        end
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            qv.push_back(0); qm.push_back(0); qd.push_back(0);
        end

        // Named corner bytes (R3, R4)
        step(1, 0, 'h00, "R3 zero fwd");
        step(1, 1, 'h63, "R3 zero inv");
        step(1, 0, 'h04, "R4 fwd");
        step(1, 1, 'hF2, "R4 inv");
        step(0, 0, 'h00, "R8 idle");

        // Full forward sweep back to back (R1, R6)
        for (int x = 0; x < 256; x++) step(1, 0, x, "R1 sweep");
        // Full inverse sweep back to back (R2, R6)
        for (int x = 0; x < 256; x++) step(1, 1, 255 - x, "R2 sweep");
        // Direction changing every byte with bubbles (R6, R8)
        for (int x = 0; x < 256; x++) step((x % 3) != 0 ? 1 : 0, x & 1, (x * 7 + 3) & 255, "R6 mixed");

        // Reset with bytes in flight (R7)
        step(1, 0, 'h11, "R7 preload");
        step(1, 1, 'h22, "R7 preload");
        reset_step();
        for (int k = 0; k < 3; k++) step(1, k & 1, 'h40 + k, "R7 after reset");
        for (int k = 0; k < 4; k++) step(0, 0, 0, "R8 drain");

        finish_run();
    end

endmodule